// File: doc/BRIEF.md
# Rotating Line Buffer Window Feeder

This block keeps the last few rows of an input feature map on chip and cuts K×K×CHI convolution windows out of them for a downstream multiply-accumulate unit. Each stored row is one image row with every pixel's channels in consecutive entries. The rows are never moved. A small table maps each logical row, counted from the top of the kernel, to a physical row. Moving the kernel down by the stride rotates that table, and only the stride-many newest logical rows are then refilled from the input stream.

Two window buffers work in turn. Even output columns are served from buffer 0 and odd columns from buffer 1. While the consumer reads one buffer, a fill engine copies the next window out of the line storage into the other. At the start of every output row, the first window is copied into buffer 0 before any window is offered. Kernel size, stride, zero padding, width, height and channel count are set at run time when `start` is pulsed. Padding positions become zeros and are never fetched from the stream.

The controller is a five-state machine:
- IDLE waits for `start` (transition *launch*) and moves to LOAD.
- LOAD writes rows into line storage. When the last element of the bottom logical row is written (*rows_filled*), it moves to INIT_WIN.
- INIT_WIN copies the column-0 window into buffer 0. When the window is complete (*first_window_done*), it moves to SERVE.
- SERVE hands windows to the consumer and refills the free buffer. The last window of a row (*row_done*) leads to ROTATE. The last window of the frame (*frame_done*) leads back to IDLE.
- ROTATE takes one cycle to rotate the index table and advance the output row (*advance*), then returns to LOAD.

Top module: `lbf_window_feeder`

## Requirements
- R1: On `start` in IDLE the six configuration inputs are captured and `busy` rises. `busy` stays high until the last window of the frame is accepted, and it is low in the cycle after that. A `start` pulse or configuration change while `busy` is high has no effect on the frame.
- R2: Output width is (W+2P−K)/S+1 and output height is (H+2P−K)/S+1, using integer division. Windows are offered in row-major order. `win_row_last` is high with the last window of each output row. `win_frame_last` is high only with the final window of the frame.
- R3: In the window for output row r and column c, read address (kr·K+kc)·CHI+ch returns input value (r·S+kr−P, c·S+kc−P, ch). It returns zero when that row or column lies outside the input.
- R4: Stream beats are taken in row-major order, pixel by pixel, with all CHI channels of a pixel on consecutive beats. Every input row is taken exactly once per frame. Only rows that some window uses are taken, which gives min(H, (Hout−1)·S+K−P) rows of W·CHI beats in total.
- R5: Zero padding is produced internally. No beat is taken for a padded row or column, so frames with P>0 consume the same beat count as the formula in R4.
- R6: Moving down one output row reloads only the S newest logical rows. Rows already held are reused through index rotation, so that windows spanning old and new rows are still correct by R3.
- R7: If the consumer holds a window for at least K·K·CHI cycles, the next window of the same row is valid in the cycle after the handshake.
- R8: While `win_valid` is high and `win_ready` is low, the window, its contents and its flags stay unchanged. Stream stalls (`in_valid` low) do not corrupt any window.
- R9: `in_ready` is low in IDLE and whenever a window is being offered. Beats presented then are not taken.
- R10: After reset, `busy`, `win_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame with the current configuration |
| cfg_width | input | WW | Input width W in pixels |
| cfg_height | input | HW | Input height H in rows |
| cfg_chans | input | CW | Input channel count CHI |
| cfg_kernel | input | KW | Kernel size K (1..K_MAX) |
| cfg_stride | input | KW | Stride S (1..K) |
| cfg_pad | input | KW | Zero padding P (< K) |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Stream beat taken this cycle when valid |
| in_data | input | DW | One channel value per beat |
| win_valid | output | 1 | A complete window is offered |
| win_ready | input | 1 | Consumer releases the offered window |
| win_rd_addr | input | WAW | Element address within the offered window |
| win_rd_data | output | DW | Element at `win_rd_addr` (combinational) |
| win_row_last | output | 1 | Offered window is the last of its output row |
| win_frame_last | output | 1 | Offered window is the last of the frame |
| busy | output | 1 | A frame is in progress |

## Verification
The bench runs frames with padding on both edges, stride equal to the kernel, a 1×1 kernel and several channel counts. Each frame targets a specific failure mode:
- A rotation in the wrong direction or by the wrong amount would show windows whose upper rows come from the wrong image row.
- A horizontal pointer that starts or steps wrongly would shift odd columns.
- Padding fetched from the stream would desynchronise every later pixel and change the consumed beat count.

A slow consumer combined with a gapped stream checks that the idle buffer is prefilled and that held windows stay stable. A stray `start` carrying a different configuration mid-frame, and beats offered while idle, must both leave the data unchanged.

// File: rtl/lbf_pkg.sv
package lbf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_INIT_WIN,
        ST_SERVE,
        ST_ROTATE
    } lbf_state_e;

endpackage

// File: rtl/lbf_row_store.sv
module lbf_row_store #(
    parameter int DW      = 8,
    parameter int K_MAX   = 3,
    parameter int ROW_LEN = 32,
    parameter int KW      = 2,
    parameter int LRW     = 2,
    parameter int RAW     = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           init,
    input  logic           rot_en,
    input  logic [KW-1:0]  kernel,
    input  logic [KW-1:0]  stride,
    input  logic           wr_en,
    input  logic [LRW-1:0] wr_lrow,
    input  logic [RAW-1:0] wr_col,
    input  logic [DW-1:0]  wr_data,
    input  logic [LRW-1:0] rd_lrow,
    input  logic [RAW-1:0] rd_col,
    output logic [DW-1:0]  rd_data
);

    logic [DW-1:0]  mem [K_MAX][ROW_LEN];
    logic [LRW-1:0] idx [K_MAX];
    logic [LRW-1:0] rot_next [K_MAX];
    logic [K_MAX-1:0] seen;

    // rotation: logical row i takes the physical row that sat S rows below it
    always_comb begin
        for (int i = 0; i < K_MAX; i++) begin
            int src;
            src = i + int'(stride);
            if (src >= int'(kernel)) src = src - int'(kernel);
            rot_next[i] = idx[i];
            if (i < int'(kernel)) rot_next[i] = idx[src[LRW-1:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < K_MAX; i++) idx[i] <= LRW'(i);
        end else if (init) begin
            for (int i = 0; i < K_MAX; i++) idx[i] <= LRW'(i);
        end else if (rot_en) begin
            for (int i = 0; i < K_MAX; i++) idx[i] <= rot_next[i];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[idx[wr_lrow]][wr_col] <= wr_data;
    end

    assign rd_data = mem[idx[rd_lrow]][rd_col];

    always_comb begin
        seen = '0;
        for (int i = 0; i < K_MAX; i++) seen[idx[i]] = 1'b1;
    end

    AST_IDX_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        (&seen)); // R6

endmodule

// File: rtl/lbf_win_pair.sv
module lbf_win_pair #(
    parameter int DW      = 8,
    parameter int WIN_LEN = 36,
    parameter int WAW     = 6
) (
    input  logic           clk,
    input  logic           we,
    input  logic           wbuf,
    input  logic [WAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic           rbuf,
    input  logic [WAW-1:0] raddr,
    output logic [DW-1:0]  rdata
);

    logic [DW-1:0] rd_b [2];

    for (genvar b = 0; b < 2; b++) begin : g_buf
        logic [DW-1:0] mem [WIN_LEN];
        always_ff @(posedge clk) begin
            if (we && (wbuf == 1'(b))) mem[waddr] <= wdata;
        end
        assign rd_b[b] = mem[raddr];
    end

    assign rdata = rbuf ? rd_b[1] : rd_b[0];

endmodule

// File: rtl/lbf_win_fill.sv
module lbf_win_fill #(
    parameter int KW  = 2,
    parameter int CW  = 3,
    parameter int WAW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           step,
    input  logic [KW-1:0]  kernel,
    input  logic [CW-1:0]  chans,
    output logic [KW-1:0]  kr,
    output logic [KW-1:0]  kc,
    output logic [CW-1:0]  ch,
    output logic [WAW-1:0] waddr,
    output logic           last
);

    logic ch_end, kc_end, kr_end;

    assign ch_end = (int'(ch) == int'(chans) - 1);
    assign kc_end = (int'(kc) == int'(kernel) - 1);
    assign kr_end = (int'(kr) == int'(kernel) - 1);
    assign last   = ch_end && kc_end && kr_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kr    <= '0;
            kc    <= '0;
            ch    <= '0;
            waddr <= '0;
        end else if (clear) begin
            kr    <= '0;
            kc    <= '0;
            ch    <= '0;
            waddr <= '0;
        end else if (step) begin
            if (last) begin
                kr    <= '0;
                kc    <= '0;
                ch    <= '0;
                waddr <= '0;
            end else begin
                waddr <= waddr + 1'b1;
                if (!ch_end) begin
                    ch <= ch + 1'b1;
                end else begin
                    ch <= '0;
                    if (!kc_end) begin
                        kc <= kc + 1'b1;
                    end else begin
                        kc <= '0;
                        kr <= kr + 1'b1;
                    end
                end
            end
        end
    end

    AST_FILL_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last && !clear) |=> (waddr == '0)); // R3

endmodule

// File: rtl/lbf_window_feeder.sv
module lbf_window_feeder #(
    parameter int DW      = 8,
    parameter int K_MAX   = 3,
    parameter int W_MAX   = 8,
    parameter int H_MAX   = 16,
    parameter int CHI_MAX = 4,
    localparam int KW      = $clog2(K_MAX + 1),
    localparam int WW      = $clog2(W_MAX + 1),
    localparam int HW      = $clog2(H_MAX + 1),
    localparam int CW      = $clog2(CHI_MAX + 1),
    localparam int ROW_LEN = W_MAX * CHI_MAX,
    localparam int RAW     = (ROW_LEN > 1) ? $clog2(ROW_LEN) : 1,
    localparam int WIN_LEN = K_MAX * K_MAX * CHI_MAX,
    localparam int WAW     = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1,
    localparam int LRW     = (K_MAX > 1) ? $clog2(K_MAX) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [WW-1:0]  cfg_width,
    input  logic [HW-1:0]  cfg_height,
    input  logic [CW-1:0]  cfg_chans,
    input  logic [KW-1:0]  cfg_kernel,
    input  logic [KW-1:0]  cfg_stride,
    input  logic [KW-1:0]  cfg_pad,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [DW-1:0]  in_data,
    output logic           win_valid,
    input  logic           win_ready,
    input  logic [WAW-1:0] win_rd_addr,
    output logic [DW-1:0]  win_rd_data,
    output logic           win_row_last,
    output logic           win_frame_last,
    output logic           busy
);

    import lbf_pkg::*;

    lbf_state_e state_q, state_d;

    // captured configuration
    logic [WW-1:0] c_w;
    logic [HW-1:0] c_h;
    logic [CW-1:0] c_ch;
    logic [KW-1:0] c_k, c_s, c_p;

    int w_i, h_i, ch_i, k_i, s_i, p_i, row_len_i, out_w_i, out_h_i;

    always_comb begin
        w_i       = int'(c_w);
        h_i       = int'(c_h);
        ch_i      = int'(c_ch);
        k_i       = int'(c_k);
        s_i       = (c_s == '0) ? 1 : int'(c_s);
        p_i       = int'(c_p);
        row_len_i = w_i * ch_i;
        out_w_i   = (w_i + 2 * p_i - k_i) / s_i + 1;
        out_h_i   = (h_i + 2 * p_i - k_i) / s_i + 1;
    end

    // progress counters
    logic [15:0]    out_row, fill_col, cons_col, ptr0, ptr1;
    logic [LRW-1:0] ld_lrow;
    logic [RAW-1:0] ld_col;
    logic [1:0]     buf_full;

    // ---------------- load path ----------------
    int   ld_ir;
    logic row_real, lb_we, ld_elem_last, ld_final;

    always_comb begin
        ld_ir        = int'(out_row) * s_i + int'(ld_lrow) - p_i;
        row_real     = (ld_ir >= 0) && (ld_ir < h_i);
        lb_we        = (state_q == ST_LOAD) && (!row_real || in_valid);
        ld_elem_last = (int'(ld_col) == row_len_i - 1);
        ld_final     = ld_elem_last && (int'(ld_lrow) == k_i - 1);
    end

    // ---------------- fill path ----------------
    logic [KW-1:0]  fill_kr, fill_kc;
    logic [CW-1:0]  fill_ch;
    logic [WAW-1:0] fill_waddr;
    logic           fill_last, fill_go, fill_buf, cons_buf;
    logic [15:0]    fill_ptr;
    int             epos;
    logic           epos_in;
    logic [RAW-1:0] lb_rd_col;
    logic [DW-1:0]  lb_rd_data, fill_data;

    assign fill_buf = fill_col[0];
    assign cons_buf = cons_col[0];
    assign fill_ptr = fill_buf ? ptr1 : ptr0;

    always_comb begin
        fill_go = (state_q == ST_INIT_WIN) ||
                  ((state_q == ST_SERVE) && (int'(fill_col) < out_w_i) && !buf_full[fill_buf]);
        epos      = int'(fill_ptr) + int'(fill_kc) * ch_i + int'(fill_ch) - p_i * ch_i;
        epos_in   = (epos >= 0) && (epos < row_len_i);
        lb_rd_col = epos_in ? epos[RAW-1:0] : '0;
        fill_data = epos_in ? lb_rd_data : '0;
    end

    // ---------------- consumer side ----------------
    logic win_fire, row_end, frame_end;

    always_comb begin
        win_valid      = (state_q == ST_SERVE) && buf_full[cons_buf];
        win_fire       = win_valid && win_ready;
        win_row_last   = win_valid && (int'(cons_col) == out_w_i - 1);
        win_frame_last = win_row_last && (int'(out_row) == out_h_i - 1);
        row_end        = win_fire && win_row_last;
        frame_end      = win_fire && win_frame_last;
    end

    // ---------------- submodules ----------------
    lbf_row_store #(
        .DW(DW), .K_MAX(K_MAX), .ROW_LEN(ROW_LEN), .KW(KW), .LRW(LRW), .RAW(RAW)
    ) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    ((state_q == ST_IDLE) && start),
        .rot_en  (state_q == ST_ROTATE),
        .kernel  (c_k),
        .stride  (c_s),
        .wr_en   (lb_we),
        .wr_lrow (ld_lrow),
        .wr_col  (ld_col),
        .wr_data (row_real ? in_data : '0),
        .rd_lrow (LRW'(fill_kr)),
        .rd_col  (lb_rd_col),
        .rd_data (lb_rd_data)
    );

    lbf_win_fill #(.KW(KW), .CW(CW), .WAW(WAW)) u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state_q == ST_IDLE),
        .step   (fill_go),
        .kernel (c_k),
        .chans  (c_ch),
        .kr     (fill_kr),
        .kc     (fill_kc),
        .ch     (fill_ch),
        .waddr  (fill_waddr),
        .last   (fill_last)
    );

    lbf_win_pair #(.DW(DW), .WIN_LEN(WIN_LEN), .WAW(WAW)) u_wins (
        .clk   (clk),
        .we    (fill_go),
        .wbuf  (fill_buf),
        .waddr (fill_waddr),
        .wdata (fill_data),
        .rbuf  (cons_buf),
        .raddr (win_rd_addr),
        .rdata (win_rd_data)
    );

    // ---------------- state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)                  state_d = ST_LOAD;      // launch
            ST_LOAD:     if (lb_we && ld_final)      state_d = ST_INIT_WIN;  // rows_filled
            ST_INIT_WIN: if (fill_last)              state_d = ST_SERVE;     // first_window_done
            ST_SERVE: begin
                if (frame_end)                       state_d = ST_IDLE;      // frame_done
                else if (row_end)                    state_d = ST_ROTATE;    // row_done
            end
            ST_ROTATE:                               state_d = ST_LOAD;      // advance
            default:                                 state_d = ST_IDLE;
        endcase
    end

    // outputs that follow the state
    always_comb begin
        busy     = (state_q != ST_IDLE);
        in_ready = (state_q == ST_LOAD) && row_real;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_w      <= '0;
            c_h      <= '0;
            c_ch     <= '0;
            c_k      <= '0;
            c_s      <= '0;
            c_p      <= '0;
            out_row  <= '0;
            fill_col <= '0;
            cons_col <= '0;
            ptr0     <= '0;
            ptr1     <= '0;
            ld_lrow  <= '0;
            ld_col   <= '0;
            buf_full <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        c_w     <= cfg_width;
                        c_h     <= cfg_height;
                        c_ch    <= cfg_chans;
                        c_k     <= cfg_kernel;
                        c_s     <= cfg_stride;
                        c_p     <= cfg_pad;
                        out_row <= '0;
                        ld_lrow <= '0;
                        ld_col  <= '0;
                    end
                end
                ST_LOAD: begin
                    if (lb_we) begin
                        if (ld_elem_last) begin
                            ld_col  <= '0;
                            ld_lrow <= ld_lrow + 1'b1;
                        end else begin
                            ld_col <= ld_col + 1'b1;
                        end
                        if (ld_final) begin
                            ptr0     <= '0;
                            ptr1     <= 16'(s_i * ch_i);
                            fill_col <= '0;
                            cons_col <= '0;
                            buf_full <= '0;
                        end
                    end
                end
                ST_INIT_WIN: begin
                    if (fill_last) begin
                        buf_full[0] <= 1'b1;
                        fill_col    <= 16'd1;
                        ptr0        <= ptr0 + 16'(2 * s_i * ch_i);
                    end
                end
                ST_SERVE: begin
                    if (win_fire) begin
                        buf_full[cons_buf] <= 1'b0;
                        cons_col           <= cons_col + 1'b1;
                    end
                    if (fill_go && fill_last) begin
                        buf_full[fill_buf] <= 1'b1;
                        fill_col           <= fill_col + 1'b1;
                        if (fill_buf) ptr1 <= ptr1 + 16'(2 * s_i * ch_i);
                        else          ptr0 <= ptr0 + 16'(2 * s_i * ch_i);
                    end
                end
                ST_ROTATE: begin
                    out_row <= out_row + 1'b1;
                    ld_lrow <= LRW'(k_i - s_i);
                    ld_col  <= '0;
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    AST_WIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !win_ready) |=> win_valid); // R8

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !win_ready) |=> ($stable(win_row_last) && $stable(win_frame_last))); // R2

    AST_FRAME_ENDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        win_frame_last |-> win_row_last); // R2

    AST_NO_STREAM_WHILE_OFFERING: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> !in_ready); // R9

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R1

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && fill_go) |-> (fill_buf != cons_buf)); // R7

endmodule

// File: tb/lbf_window_feeder_tb_top.sv
`timescale 1ns/1ps
module lbf_window_feeder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8, K_MAX = 3, W_MAX = 8, H_MAX = 16, CHI_MAX = 4;
    localparam int SRC_LEN = H_MAX * W_MAX * CHI_MAX;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] cfg_width = '0;
    logic [4:0] cfg_height = '0;
    logic [2:0] cfg_chans = '0;
    logic [1:0] cfg_kernel = '0, cfg_stride = '0, cfg_pad = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       win_valid;
    logic       win_ready = 1'b0;
    logic [5:0] win_rd_addr = '0;
    logic [7:0] win_rd_data;
    logic       win_row_last, win_frame_last, busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    lbf_window_feeder #(.DW(DW), .K_MAX(K_MAX), .W_MAX(W_MAX), .H_MAX(H_MAX), .CHI_MAX(CHI_MAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_chans(cfg_chans),
        .cfg_kernel(cfg_kernel), .cfg_stride(cfg_stride), .cfg_pad(cfg_pad),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .win_valid(win_valid), .win_ready(win_ready), .win_rd_addr(win_rd_addr),
        .win_rd_data(win_rd_data), .win_row_last(win_row_last),
        .win_frame_last(win_frame_last), .busy(busy)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // stream source
    logic [7:0] src [SRC_LEN];
    int  src_n = 0, src_idx = 0, gcnt = 0;
    bit  src_en = 0, gap = 0, pend = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (pend) src_idx++;
            gcnt++;
            in_valid = src_en && (src_idx < src_n) && !(gap && (gcnt % 3 == 0));
            in_data  = (src_idx < SRC_LEN) ? src[src_idx] : 8'h00;
            pend     = in_valid && in_ready;
        end
    end

    int cw, ch, cc, ck, cs, cp, cseed;

    function automatic logic [7:0] pix(int r, int c, int chn);
        return 8'(((r * 37 + c * 11 + chn * 5 + cseed) % 251) + 1);
    endfunction

    function automatic int expv(int r, int c, int kr, int kc, int chn);
        int ir, ic;
        ir = r * cs + kr - cp;
        ic = c * cs + kc - cp;
        if (ir < 0 || ir >= ch || ic < 0 || ic >= cw) return 0;
        return int'(pix(ir, ic, chn));
    endfunction

    // one scenario: configure, stream, consume and check every window
    task automatic run_frame(input int w, input int h, input int chans, input int k,
                             input int s, input int p, input int seed,
                             input int hold, input bit gapped, input bit poke, input string tag);
        int wo, ho, rows_used, mism, first_bad_a, first_bad_e;
        src_en = 0;
        repeat (2) @(negedge clk);
        cw = w; ch = h; cc = chans; ck = k; cs = s; cp = p; cseed = seed;
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                for (int q = 0; q < chans; q++)
                    src[(r * w + c) * chans + q] = pix(r, c, q);
        @(posedge clk); #1;
        src_idx = 0; pend = 0; src_n = h * w * chans; gap = gapped;
        wo = (w + 2 * p - k) / s + 1;
        ho = (h + 2 * p - k) / s + 1;
        rows_used = (ho - 1) * s + k - p;
        if (rows_used > h) rows_used = h;
        @(negedge clk);
        cfg_width = 4'(w); cfg_height = 5'(h); cfg_chans = 3'(chans);
        cfg_kernel = 2'(k); cfg_stride = 2'(s); cfg_pad = 2'(p);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        src_en = 1;
        for (int r = 0; r < ho; r++) begin
            for (int c = 0; c < wo; c++) begin
                while (!win_valid) @(negedge clk);
                if (poke && r == 0 && c == 1) begin
                    cfg_kernel = 2'd1; cfg_width = 4'd2; cfg_pad = 2'd0; start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                    cfg_width = 4'(w); cfg_kernel = 2'(k); cfg_pad = 2'(p);
                    chk(busy && win_valid, {tag, " R1 start while busy ignored"}, int'(busy), 1);
                end
                mism = 0; first_bad_a = 0; first_bad_e = 0;
                for (int kr = 0; kr < k; kr++)
                    for (int kc = 0; kc < k; kc++)
                        for (int q = 0; q < chans; q++) begin
                            win_rd_addr = 6'((kr * k + kc) * chans + q);
                            #1;
                            if (int'(win_rd_data) != expv(r, c, kr, kc, q)) begin
                                if (mism == 0) begin
                                    first_bad_a = int'(win_rd_data);
                                    first_bad_e = expv(r, c, kr, kc, q);
                                end
                                mism++;
                            end
                        end
                // R3 R5 R6 R8: window contents
                chk(mism == 0, $sformatf("%s R3 window r%0d c%0d", tag, r, c), first_bad_a, first_bad_e);
                @(negedge clk);
                // R2: order flags
                chk((win_row_last == (c == wo - 1)) && (win_frame_last == (r == ho - 1 && c == wo - 1)),
                    $sformatf("%s R2 flags r%0d c%0d", tag, r, c),
                    int'({win_row_last, win_frame_last}),
                    int'({(c == wo - 1), (r == ho - 1 && c == wo - 1)}));
                repeat (hold) @(negedge clk);
                win_ready = 1'b1;
                @(negedge clk);
                win_ready = 1'b0;
                if (hold >= k * k * chans && c < wo - 1)
                    chk(win_valid, $sformatf("%s R7 next window ready r%0d c%0d", tag, r, c), int'(win_valid), 1);
            end
        end
        chk(!busy, {tag, " R1 busy low after last window"}, int'(busy), 0);
        @(negedge clk); #1;
        chk(src_idx == rows_used * w * chans, {tag, " R4 R5 beats consumed"}, src_idx, rows_used * w * chans);
        src_en = 0;
    endtask

    task automatic test_reset();
        chk(!busy && !win_valid && !in_ready, "R10 reset outputs", int'({busy, win_valid, in_ready}), 0);
    endtask

    task automatic test_idle_ignore();
        for (int i = 0; i < 8; i++) src[i] = 8'(i + 1);
        @(posedge clk); #1;
        src_idx = 0; pend = 0; src_n = 8; gap = 0;
        src_en = 1;
        repeat (5) @(negedge clk);
        #1;
        chk(!in_ready, "R9 in_ready low while idle", int'(in_ready), 0);
        chk(src_idx == 0, "R9 no beat taken while idle", src_idx, 0);
        src_en = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_idle_ignore();
        run_frame(5, 4, 2, 3, 1, 1, 3, 0, 0, 0, "pad1");
        run_frame(7, 7, 3, 3, 2, 0, 17, 0, 0, 1, "s2k3");
        run_frame(8, 6, 4, 2, 2, 0, 29, 0, 1, 0, "s2k2");
        run_frame(4, 3, 1, 1, 1, 0, 41, 0, 0, 0, "k1");
        run_frame(6, 5, 1, 3, 1, 0, 53, 40, 1, 0, "slow");
        run_frame(5, 5, 2, 3, 2, 1, 67, 20, 0, 0, "s2p1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule